// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counting channel of a programmable interval timer. An external clock-enable pulse (`tickEn`, nominally at about 1.19 MHz) advances the count. Software loads the initial count over an 8-bit bus as two bytes, low byte first. It reads the live count, or a latched snapshot of it, the same way. A decoded control word chooses between three counting modes or issues a latch command.

In terminal-count mode the channel counts once and then raises its output pin, which stays high. In the two periodic modes (rate generator and square wave) the counter reloads itself and gives a terminal-count event every `initial - 1` ticks, because it fires on reaching 1 and not 0. Every terminal-count event gives a one-cycle interrupt pulse. Unsupported requests raise a one-cycle error pulse and leave the channel untouched. A three-channel wrapper places three instances with `CHANNEL_ID` set to 0, 1 and 2 and shares the control-word inputs between them.

Top module: `pit_channel`

## Requirements
- R1: After reset `outPin`, `irqPulse`, `cfgError` and `rdData` are 0, and no countdown is active.
- R2: Count writes alternate low byte, then high byte. A low-byte write stops any active countdown and drives `outPin` low in the cycle after the strobe.
- R3: A high-byte write completes the initial count and starts the countdown only when `chanEnable` is 1 and the period is non-zero. Otherwise the channel stays idle.
- R4: In mode 0 (terminal count), after `initial` ticks `outPin` goes high and the countdown stops. `outPin` then stays high until the next low-byte write.
- R5: In mode 2 (rate generator) and mode 3 (square wave), the period is `initial - 1` ticks and the counter reloads at each terminal count.
- R6: A live read returns the remaining ticks in mode 0, the remaining ticks plus one in modes 2 and 3, and 0 when no countdown is active. Each read strobe loads `rdData` with one byte, the low byte first and then the high byte, and `rdData` is valid the cycle after the strobe.
- R7: A latch command (access field 0) captures the live count only when no latch is pending. The latched value is returned by the next two reads, and further latch commands are ignored until the second of those reads.
- R8: An accepted latch command returns the read pointer to the low byte.
- R9: A control word with select 3, with an access field other than 0 or 3, with a mode other than 0, 2 or 3, or with the BCD flag set raises `cfgError` for one cycle and leaves the mode unchanged.
- R10: A control word whose select field differs from `CHANNEL_ID` and is not 3 has no effect on this channel.
- R11: `irqPulse` is high for one cycle at each terminal count, and only in a cycle that follows a `tickEn` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count clock enable, one pulse per count tick |
| chanEnable | input | 1 | Allows a high-byte write to start the countdown |
| wrData | input | 8 | Count byte to write |
| wrStrobe | input | 1 | Writes one count byte |
| rdStrobe | input | 1 | Reads one count byte |
| rdData | output | 8 | Byte returned by the last read |
| ctrlValid | input | 1 | Control word present this cycle |
| ctrlSel | input | 2 | Channel select, 3 is rejected |
| ctrlAccess | input | 2 | 0 latch command, 3 low-then-high access |
| ctrlMode | input | 3 | Counting mode: 0, 2 or 3 |
| ctrlBcd | input | 1 | BCD request, always rejected |
| outPin | output | 1 | Channel output, goes high at terminal count in mode 0 |
| irqPulse | output | 1 | One-cycle terminal-count pulse |
| cfgError | output | 1 | One-cycle pulse for a rejected control word |

## Verification
The hardest case to reach is the read pointer when a latch interleaves with live reads. The stimulus reads only the live low byte, so the pointer sits on the high byte. It then ticks once and latches, and ticks again so that the live value and the latched value differ. The next read must return the latched low byte and not a high byte. A rejected control word gives no direct state to inspect, so each rejection is followed by a reload and a tick count. The interrupt spacing and the output pin show which mode survived.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [2:0] {
    MODE_TC     = 3'd0,
    MODE_RATE   = 3'd2,
    MODE_SQUARE = 3'd3
  } pit_mode_e;

  localparam logic [1:0] ACCESS_LATCH = 2'd0;
  localparam logic [1:0] ACCESS_WORD  = 2'd3;
  localparam logic [1:0] SEL_REJECT   = 2'd3;

  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic capture;
    logic rdEn;
    logic rdHigh;
    logic rdLatched;
    logic periodic;
  } pit_strobe_t;
endpackage

// File: rtl/pit_chan_ctrl.sv
module pit_chan_ctrl
  import pit_pkg::*;
#(
  parameter int CHANNEL_ID = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlValid,
  input  logic [1:0]  ctrlSel,
  input  logic [1:0]  ctrlAccess,
  input  logic [2:0]  ctrlMode,
  input  logic        ctrlBcd,
  input  logic        wrStrobe,
  input  logic        rdStrobe,
  output pit_strobe_t st,
  output logic        cfgError
);
  localparam logic [1:0] MY_SEL = 2'(CHANNEL_ID);

  pit_mode_e modeReg;
  logic writeMsb, readMsb, latchOn;
  logic hit, selBad, isLatch, modeOk, progOk, progBad;

  always_comb begin
    hit     = ctrlValid && (ctrlSel == MY_SEL) && (ctrlSel != SEL_REJECT);
    selBad  = ctrlValid && (ctrlSel == SEL_REJECT);
    isLatch = hit && (ctrlAccess == ACCESS_LATCH);
    modeOk  = (ctrlMode == MODE_TC) || (ctrlMode == MODE_RATE) || (ctrlMode == MODE_SQUARE);
    progOk  = hit && (ctrlAccess == ACCESS_WORD) && modeOk && !ctrlBcd;
    progBad = hit && (ctrlAccess != ACCESS_LATCH) && !progOk;

    st.loadLow   = wrStrobe && !writeMsb;
    st.loadHigh  = wrStrobe && writeMsb;
    st.capture   = isLatch && !latchOn;
    st.rdEn      = rdStrobe;
    st.rdHigh    = readMsb;
    st.rdLatched = latchOn;
    st.periodic  = (modeReg != MODE_TC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= MODE_TC;
      writeMsb <= 1'b0;
      readMsb  <= 1'b0;
      latchOn  <= 1'b0;
      cfgError <= 1'b0;
    end else begin
      cfgError <= selBad || progBad;
      if (progOk) modeReg <= pit_mode_e'(ctrlMode);
      if (wrStrobe) writeMsb <= !writeMsb;
      if (st.capture) begin
        latchOn <= 1'b1;
        readMsb <= 1'b0;
      end else if (rdStrobe) begin
        readMsb <= !readMsb;
        if (latchOn && readMsb) latchOn <= 1'b0;
      end
    end
  end

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchOn && !(rdStrobe && readMsb) |=> latchOn);

  // R9
  err_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> $stable(modeReg));
endmodule

// File: rtl/pit_chan_datapath.sv
module pit_chan_datapath
  import pit_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             chanEnable,
  input  logic [BUS_W-1:0] wrData,
  input  pit_strobe_t      st,
  output logic [BUS_W-1:0] rdData,
  output logic             outPin,
  output logic             irqPulse
);
  localparam int CNT_W = 2 * BUS_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] initCount, periodReg, cnt, latched;
  logic [CNT_W-1:0] lowMerged, highMerged, newPeriod, liveCount, rdWord;
  logic active, terminal;

  always_comb begin
    lowMerged  = {initCount[CNT_W-1:BUS_W], wrData};
    highMerged = {wrData, initCount[BUS_W-1:0]};
    newPeriod  = st.periodic ? highMerged - ONE : highMerged;
    if (!active)          liveCount = '0;
    else if (st.periodic) liveCount = cnt + ONE;
    else                  liveCount = cnt;
    terminal = active && tickEn && (cnt == ONE);
    rdWord   = st.rdLatched ? latched : liveCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initCount <= '0;
      periodReg <= '0;
      cnt       <= '0;
      latched   <= '0;
      active    <= 1'b0;
      outPin    <= 1'b0;
      irqPulse  <= 1'b0;
      rdData    <= '0;
    end else begin
      irqPulse <= terminal && !st.loadLow && !st.loadHigh;
      if (st.loadLow) begin
        initCount <= lowMerged;
        active    <= 1'b0;
        outPin    <= 1'b0;
      end else if (st.loadHigh) begin
        initCount <= highMerged;
        periodReg <= newPeriod;
        if (chanEnable && (newPeriod != '0)) begin
          cnt    <= newPeriod;
          active <= 1'b1;
        end
      end else if (terminal) begin
        if (st.periodic) begin
          cnt <= periodReg;
        end else begin
          outPin <= 1'b1;
          active <= 1'b0;
        end
      end else if (active && tickEn) begin
        cnt <= cnt - ONE;
      end
      if (st.capture) latched <= liveCount;
      if (st.rdEn) rdData <= st.rdHigh ? rdWord[CNT_W-1:BUS_W] : rdWord[BUS_W-1:0];
    end
  end

  // R11
  irq_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(tickEn));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outPin && !st.loadLow |=> outPin);

  // R3
  active_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (cnt != '0));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CHANNEL_ID = 0,
  parameter int BUS_W      = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             chanEnable,
  input  logic [BUS_W-1:0] wrData,
  input  logic             wrStrobe,
  input  logic             rdStrobe,
  output logic [BUS_W-1:0] rdData,
  input  logic             ctrlValid,
  input  logic [1:0]       ctrlSel,
  input  logic [1:0]       ctrlAccess,
  input  logic [2:0]       ctrlMode,
  input  logic             ctrlBcd,
  output logic             outPin,
  output logic             irqPulse,
  output logic             cfgError
);
  pit_strobe_t st;

  pit_chan_ctrl #(.CHANNEL_ID(CHANNEL_ID)) i_ctrl (
    .clk(clk), .rstN(rstN), .ctrlValid(ctrlValid), .ctrlSel(ctrlSel),
    .ctrlAccess(ctrlAccess), .ctrlMode(ctrlMode), .ctrlBcd(ctrlBcd),
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .st(st), .cfgError(cfgError)
  );

  pit_chan_datapath #(.BUS_W(BUS_W)) i_datapath (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .chanEnable(chanEnable),
    .wrData(wrData), .st(st), .rdData(rdData), .outPin(outPin), .irqPulse(irqPulse)
  );
endmodule

// File: tb/test_pit_channel.sv
module test_pit_channel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, chanEnable = 1'b1;
  logic [7:0] wrData = '0;
  logic wrStrobe = 1'b0, rdStrobe = 1'b0;
  logic [7:0] rdData;
  logic ctrlValid = 1'b0;
  logic [1:0] ctrlSel = '0, ctrlAccess = '0;
  logic [2:0] ctrlMode = '0;
  logic ctrlBcd = 1'b0;
  logic outPin, irqPulse, cfgError;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = !clk;

  pit_channel i_pit_channel (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .chanEnable(chanEnable),
    .wrData(wrData), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .rdData(rdData),
    .ctrlValid(ctrlValid), .ctrlSel(ctrlSel), .ctrlAccess(ctrlAccess),
    .ctrlMode(ctrlMode), .ctrlBcd(ctrlBcd),
    .outPin(outPin), .irqPulse(irqPulse), .cfgError(cfgError)
  );

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic writeByte(logic [7:0] b);
    @(negedge clk); wrData = b; wrStrobe = 1'b1;
    @(negedge clk); wrStrobe = 1'b0;
  endtask

  task automatic writeCount(logic [15:0] v);
    writeByte(v[7:0]);
    writeByte(v[15:8]);
  endtask

  task automatic readByte(output logic [7:0] b);
    @(negedge clk); rdStrobe = 1'b1;
    @(negedge clk); rdStrobe = 1'b0; b = rdData;
  endtask

  task automatic readWord(output logic [15:0] w);
    logic [7:0] lo, hi;
    readByte(lo);
    readByte(hi);
    w = {hi, lo};
  endtask

  task automatic ctrl(logic [1:0] sel, logic [1:0] acc, logic [2:0] mode, logic bcd,
                      output logic err);
    @(negedge clk);
    ctrlValid = 1'b1; ctrlSel = sel; ctrlAccess = acc; ctrlMode = mode; ctrlBcd = bcd;
    @(negedge clk); ctrlValid = 1'b0; err = cfgError;
  endtask

  task automatic tick(output logic irq);
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0; irq = irqPulse;
  endtask

  task automatic runTicks(int n, int period, string tag);
    logic irq;
    for (int i = 1; i <= n; i++) begin
      tick(irq);
      check(tag, int'(irq), (period != 0 && (i % period) == 0) ? 1 : 0);
    end
  endtask

  task automatic testReset();
    logic [15:0] w;
    check("R1 outPin", int'(outPin), 0);
    check("R1 irqPulse", int'(irqPulse), 0);
    check("R1 cfgError", int'(cfgError), 0);
    check("R1 rdData", int'(rdData), 0);
    readWord(w);
    check("R1/R6 idle live read", int'(w), 0);
  endtask

  task automatic testTerminal();
    logic err, irq;
    logic [15:0] w;
    ctrl(2'd0, 2'd3, 3'd0, 1'b0, err);
    check("R9 mode0 accepted", int'(err), 0);
    writeCount(16'd5);
    readWord(w);
    check("R3/R6 mode0 start count", int'(w), 5);
    runTicks(3, 0, "R4 no early irq");
    readWord(w);
    check("R6 mode0 remaining", int'(w), 2);
    tick(irq);
    check("R4 tick4 no irq", int'(irq), 0);
    tick(irq);
    check("R11 irq at terminal", int'(irq), 1);
    check("R4 outPin high", int'(outPin), 1);
    @(negedge clk);
    check("R11 irq single cycle", int'(irqPulse), 0);
    readWord(w);
    check("R4 stopped live read", int'(w), 0);
    runTicks(3, 0, "R4 no repeat irq");
    check("R4 outPin stays high", int'(outPin), 1);
  endtask

  task automatic testLowWrite();
    logic [15:0] w;
    writeByte(8'd7);
    check("R2 low write drops outPin", int'(outPin), 0);
    writeByte(8'd0);
    readWord(w);
    check("R2 restart count", int'(w), 7);
    writeByte(8'd9);
    readWord(w);
    check("R2 low write stops count", int'(w), 0);
    runTicks(10, 0, "R2 stopped no irq");
    writeByte(8'd0);
    readWord(w);
    check("R2 high write completes", int'(w), 9);
  endtask

  task automatic testPeriodic();
    logic err;
    logic [15:0] w;
    ctrl(2'd0, 2'd3, 3'd2, 1'b0, err);
    writeCount(16'd4);
    readWord(w);
    check("R6 mode2 live plus one", int'(w), 4);
    runTicks(7, 3, "R5 mode2 period");
    check("R5 mode2 outPin low", int'(outPin), 0);
    ctrl(2'd0, 2'd3, 3'd3, 1'b0, err);
    check("R9 mode3 accepted", int'(err), 0);
    writeCount(16'd3);
    runTicks(5, 2, "R5 mode3 period");
    ctrl(2'd0, 2'd3, 3'd2, 1'b0, err);
    writeCount(16'd1);
    readWord(w);
    check("R3 zero period idle", int'(w), 0);
    runTicks(3, 0, "R3 zero period no irq");
  endtask

  task automatic testEnable();
    logic err;
    logic [15:0] w;
    ctrl(2'd0, 2'd3, 3'd0, 1'b0, err);
    chanEnable = 1'b0;
    writeCount(16'd5);
    readWord(w);
    check("R3 disabled idle", int'(w), 0);
    runTicks(6, 0, "R3 disabled no irq");
    chanEnable = 1'b1;
  endtask

  task automatic testLatch();
    logic err;
    logic irq;
    logic [7:0] b;
    ctrl(2'd0, 2'd3, 3'd0, 1'b0, err);
    writeCount(16'h1234);
    ctrl(2'd0, 2'd0, 3'd0, 1'b0, err);
    check("R7 latch not an error", int'(err), 0);
    runTicks(3, 0, "R7 ticks");
    ctrl(2'd0, 2'd0, 3'd0, 1'b0, err);
    readByte(b);
    check("R7 latched low", int'(b), 8'h34);
    readByte(b);
    check("R7 latched high", int'(b), 8'h12);
    readByte(b);
    check("R7 live after latch low", int'(b), 8'h31);
    readByte(b);
    check("R7 live after latch high", int'(b), 8'h12);
    // R8: pointer left on high byte, then latch
    readByte(b);
    check("R8 live low", int'(b), 8'h31);
    tick(irq);
    ctrl(2'd0, 2'd0, 3'd0, 1'b0, err);
    tick(irq);
    readByte(b);
    check("R8 pointer reset to latched low", int'(b), 8'h30);
    readByte(b);
    check("R8 latched high", int'(b), 8'h12);
    readByte(b);
    check("R8 live low after release", int'(b), 8'h2F);
    readByte(b);
  endtask

  task automatic testErrors();
    logic err;
    logic [15:0] w;
    ctrl(2'd0, 2'd3, 3'd2, 1'b0, err);
    ctrl(2'd0, 2'd3, 3'd1, 1'b0, err);
    check("R9 bad mode error", int'(err), 1);
    @(negedge clk);
    check("R9 error one cycle", int'(cfgError), 0);
    ctrl(2'd0, 2'd3, 3'd0, 1'b1, err);
    check("R9 bcd error", int'(err), 1);
    ctrl(2'd0, 2'd1, 3'd0, 1'b0, err);
    check("R9 access error", int'(err), 1);
    ctrl(2'd3, 2'd3, 3'd0, 1'b0, err);
    check("R9 select 3 error", int'(err), 1);
    writeCount(16'd4);
    readWord(w);
    check("R9 mode kept live read", int'(w), 4);
    runTicks(6, 3, "R9 mode2 kept");
    check("R9 outPin low", int'(outPin), 0);
    ctrl(2'd1, 2'd3, 3'd0, 1'b0, err);
    check("R10 other channel no error", int'(err), 0);
    writeCount(16'd4);
    runTicks(6, 3, "R10 mode unchanged");
    check("R10 outPin low", int'(outPin), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTerminal();
    testLowWrite();
    testPeriodic();
    testEnable();
    testLatch();
    testErrors();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-R11 run actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule